// File: doc/BRIEF.md
# Packed Tag Memory Update Unit

This unit reads and writes 4-bit allocation tags. Each tag guards one 16-byte data granule, and two tags share one byte of an external tag RAM. The caller presents an operation code, a data address, a tag and a 64-bit operand. The unit turns the request into a short sequence of byte reads and writes on the RAM port. Storing a single tag needs a read-modify-write so that the neighbouring nibble survives. Storing a tag on two granules that share one byte writes that byte once, with the tag in both nibbles.

Besides single-tag load and store, the unit moves 16 tags at a time as one 64-bit word, covering an aligned 256-byte region. It can also paint one tag over every granule of an aligned zeroing block, whose size is a parameter. Store requests whose address is not granule-aligned are refused with a fault. A request is taken only while the unit is idle. Completion is signalled by a one-cycle done pulse, and any load result is valid while done is high.

Top module: `tag_mem_unit`

## Requirements
- R1: After reset busy, done, fault, ramRdEn and ramWrEn are 0 and respData is 0.
- R2: A request (reqValid high) is taken only while busy is 0. busy is 1 from the cycle after acceptance through the done cycle, done lasts exactly one cycle, and busy is 0 in the cycle after done. Requests presented while busy have no effect.
- R3: The tag byte address is the data address shifted right by 5. Address bit 4 selects the nibble: 0 selects bits 3:0 and 1 selects bits 7:4.
- R4: A single store (op 1) or pair store (op 2) whose address bits 3:0 are not all zero completes with fault=1 in the done cycle and performs no RAM write. No other operation raises fault.
- R5: A single store reads the tag byte and writes it back with only the selected nibble replaced by reqTag, using one read and one write.
- R6: A pair store at an odd granule (address bit 4 = 1) sets the high nibble of tag byte B and the low nibble of byte B+1 to reqTag and leaves the other nibbles unchanged. It uses two writes.
- R7: A pair store at an even granule writes tag byte B once, with reqTag in both nibbles and no read.
- R8: A single load (op 0) returns respData equal to reqData with bits 59:56 replaced by the selected nibble. It writes nothing.
- R9: A bulk load (op 3) aligns the data address down to 256 bytes and reads 8 tag bytes from the aligned byte address upward. Byte i of respData (bits 8i+7:8i) is the byte at offset i.
- R10: A bulk store (op 4) uses the same alignment and writes byte i of reqData to offset i, 8 writes in all.
- R11: A fill (op 5) aligns the data address down to ZB_BYTES and writes all ZB_BYTES/32 covered tag bytes with reqData bits 3:0 in both nibbles.
- R12: Op codes 6 and 7 complete with a done pulse, with fault 0 and no RAM access.
- R13: The RAM read latency is one cycle. Every read-modify-write writes to the address it has just read, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is 0 |
| reqOp | input | 3 | Operation code (see R4 to R12) |
| reqAddr | input | ADDR_W | Data address |
| reqTag | input | 4 | Tag for single and pair stores |
| reqData | input | 64 | Operand for single load, bulk store and fill |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, valid with done |
| respData | output | 64 | Load result |
| ramAddr | output | ADDR_W-5 | Tag RAM byte address |
| ramRdEn | output | 1 | Tag RAM read enable |
| ramWrEn | output | 1 | Tag RAM write enable |
| ramWdata | output | 8 | Tag RAM write data |
| ramRdata | input | 8 | Tag RAM read data, one cycle after ramRdEn |

## Verification
Some properties are checked by assertions on every cycle. A rewrite after a read targets the same RAM byte, and reads and writes never overlap. Replicated-nibble writes carry equal halves. Bulk transfers walk the byte offset in step order. Done is a single pulse that drops busy, and a misaligned store goes straight to a faulting done with no write. Nibble preservation, address alignment, little-endian byte order and load results only show up in the memory contents and in respData, so the bench sweeps granules and tags against its own model of the tag RAM. It also checks that requests made while busy leave that model untouched.

// File: rtl/tagunit_pkg.sv
package tagunit_pkg;
  localparam int TAG_W      = 4;
  localparam int BYTE_SHIFT = 5;
  localparam int BULK_BYTES = 8;
  localparam int WORD_W     = 64;
  localparam int TAG_LSB    = 56;

  typedef enum logic [2:0] {
    OP_LOAD_ONE   = 3'd0,
    OP_STORE_ONE  = 3'd1,
    OP_STORE_PAIR = 3'd2,
    OP_BULK_LOAD  = 3'd3,
    OP_BULK_STORE = 3'd4,
    OP_FILL       = 3'd5
  } tagOp_e;

  typedef struct packed {
    logic latch;
    logic rdEn;
    logic wrEn;
    logic capture;
  } ctlStrobe_t;
endpackage

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import tagunit_pkg::*;
#(
  parameter int STEP_W     = 3,
  parameter int FILL_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [4:0]        reqLow,
  output ctlStrobe_t        strb,
  output logic [STEP_W-1:0] stepIdx,
  output logic              busy,
  output logic              done,
  output logic              fault
);
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_USE, ST_WR, ST_FIN} state_e;

  state_e state;
  logic [STEP_W-1:0] idxQ, lastQ;
  logic wrModeQ, faultQ;

  logic accept, useRead, useWrite, known, misStore;
  logic [STEP_W-1:0] lastStep;

  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    useRead  = 1'b0;
    useWrite = 1'b0;
    known    = 1'b1;
    lastStep = '0;
    misStore = 1'b0;
    case (reqOp)
      OP_LOAD_ONE: useRead = 1'b1;
      OP_STORE_ONE: begin
        useRead  = 1'b1;
        useWrite = 1'b1;
        misStore = (reqLow[3:0] != 4'd0);
      end
      OP_STORE_PAIR: begin
        useRead  = reqLow[4];
        useWrite = 1'b1;
        lastStep = reqLow[4] ? STEP_W'(1) : '0;
        misStore = (reqLow[3:0] != 4'd0);
      end
      OP_BULK_LOAD: begin
        useRead  = 1'b1;
        lastStep = STEP_W'(BULK_BYTES - 1);
      end
      OP_BULK_STORE: begin
        useWrite = 1'b1;
        lastStep = STEP_W'(BULK_BYTES - 1);
      end
      OP_FILL: begin
        useWrite = 1'b1;
        lastStep = STEP_W'(FILL_BYTES - 1);
      end
      default: known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idxQ    <= '0;
      lastQ   <= '0;
      wrModeQ <= 1'b0;
      faultQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          idxQ    <= '0;
          lastQ   <= lastStep;
          wrModeQ <= useWrite;
          faultQ  <= misStore;
          if (misStore || !known) state <= ST_FIN;
          else if (useRead)       state <= ST_RD;
          else                    state <= ST_WR;
        end
        ST_RD: state <= ST_USE;
        ST_USE: begin
          if (idxQ == lastQ) state <= ST_FIN;
          else begin
            idxQ  <= idxQ + 1'b1;
            state <= ST_RD;
          end
        end
        ST_WR: begin
          if (idxQ == lastQ) state <= ST_FIN;
          else idxQ <= idxQ + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latch   = accept;
    strb.rdEn    = (state == ST_RD);
    strb.wrEn    = (state == ST_WR) || ((state == ST_USE) && wrModeQ);
    strb.capture = (state == ST_USE);
  end

  assign stepIdx = idxQ;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
  assign fault   = done && faultQ;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  assert_fault_with_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done);
  assert_misaligned_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && misStore) |=> (done && fault && !strb.wrEn));
  assert_rd_wr_exclusive_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn && strb.wrEn));
endmodule

// File: rtl/tag_dpath.sv
module tag_dpath
  import tagunit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STEP_W     = 3,
  parameter int FILL_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strb,
  input  logic [STEP_W-1:0]         stepIdx,
  input  logic [2:0]                reqOp,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [TAG_W-1:0]          reqTag,
  input  logic [WORD_W-1:0]         reqData,
  input  logic [7:0]                ramRdata,
  output logic [ADDR_W-BYTE_SHIFT-1:0] ramAddr,
  output logic [7:0]                ramWdata,
  output logic [WORD_W-1:0]         respData
);
  localparam int RAM_AW = ADDR_W - BYTE_SHIFT;
  localparam logic [RAM_AW-1:0] BULK_MASK = ~RAM_AW'(BULK_BYTES - 1);
  localparam logic [RAM_AW-1:0] FILL_MASK = ~RAM_AW'(FILL_BYTES - 1);

  logic [2:0]          opQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [TAG_W-1:0]    tagQ;
  logic [WORD_W-1:0]   dataQ, respQ;
  logic [RAM_AW-1:0]   byteAddr, baseAddr;
  logic                hiSel;
  logic [TAG_W-1:0]    rdNib;
  logic [5:0]          laneLsb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= '0;
      addrQ <= '0;
      tagQ  <= '0;
      dataQ <= '0;
    end else if (strb.latch) begin
      opQ   <= reqOp;
      addrQ <= reqAddr;
      tagQ  <= reqTag;
      dataQ <= reqData;
    end
  end

  assign byteAddr = addrQ[ADDR_W-1:BYTE_SHIFT];
  assign hiSel    = addrQ[4] ^ stepIdx[0];
  assign rdNib    = addrQ[4] ? ramRdata[7:4] : ramRdata[3:0];
  assign laneLsb  = {stepIdx[2:0], 3'b000};

  always_comb begin
    case (opQ)
      OP_BULK_LOAD, OP_BULK_STORE: baseAddr = byteAddr & BULK_MASK;
      OP_FILL:                     baseAddr = byteAddr & FILL_MASK;
      default:                     baseAddr = byteAddr;
    endcase
  end

  assign ramAddr = baseAddr + RAM_AW'(stepIdx);

  always_comb begin
    case (opQ)
      OP_BULK_STORE: ramWdata = dataQ[laneLsb +: 8];
      OP_FILL:       ramWdata = {dataQ[3:0], dataQ[3:0]};
      OP_STORE_PAIR: ramWdata = addrQ[4]
                       ? (hiSel ? {tagQ, ramRdata[3:0]} : {ramRdata[7:4], tagQ})
                       : {tagQ, tagQ};
      default:       ramWdata = hiSel ? {tagQ, ramRdata[3:0]} : {ramRdata[7:4], tagQ};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) respQ <= '0;
    else if (strb.capture) begin
      if (opQ == OP_LOAD_ONE)
        respQ <= {dataQ[WORD_W-1:TAG_LSB+TAG_W], rdNib, dataQ[TAG_LSB-1:0]};
      else if (opQ == OP_BULK_LOAD)
        respQ[laneLsb +: 8] <= ramRdata;
    end
  end

  assign respData = respQ;

  assert_rmw_same_byte_R13: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && $past(strb.rdEn)) |-> (ramAddr == $past(ramAddr)));
  assert_pair_even_replicated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && opQ == OP_STORE_PAIR && !addrQ[4]) |-> (ramWdata[7:4] == ramWdata[3:0]));
  assert_fill_replicated_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && opQ == OP_FILL) |-> (ramWdata[7:4] == ramWdata[3:0]));
  assert_bulk_lane_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.rdEn || strb.wrEn) && (opQ == OP_BULK_LOAD || opQ == OP_BULK_STORE))
      |-> (ramAddr[2:0] == stepIdx[2:0]));
endmodule

// File: rtl/tag_mem_unit.sv
module tag_mem_unit
  import tagunit_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ZB_BYTES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [2:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [3:0]           reqTag,
  input  logic [63:0]          reqData,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic [63:0]          respData,
  output logic [ADDR_W-6:0]    ramAddr,
  output logic                 ramRdEn,
  output logic                 ramWrEn,
  output logic [7:0]           ramWdata,
  input  logic [7:0]           ramRdata
);
  localparam int FILL_BYTES = ZB_BYTES >> BYTE_SHIFT;
  localparam int MAX_STEPS  = (FILL_BYTES > BULK_BYTES) ? FILL_BYTES : BULK_BYTES;
  localparam int STEP_W     = $clog2(MAX_STEPS);

  ctlStrobe_t        strb;
  logic [STEP_W-1:0] stepIdx;

  tag_ctrl #(.STEP_W(STEP_W), .FILL_BYTES(FILL_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqLow(reqAddr[4:0]), .strb(strb), .stepIdx(stepIdx),
    .busy(busy), .done(done), .fault(fault)
  );

  tag_dpath #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .FILL_BYTES(FILL_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .stepIdx(stepIdx), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqTag(reqTag), .reqData(reqData), .ramRdata(ramRdata),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .respData(respData)
  );

  assign ramRdEn = strb.rdEn;
  assign ramWrEn = strb.wrEn;
endmodule

// File: tb/test_tag_mem_unit.sv
module test_tag_mem_unit;
  localparam int AW    = 14;
  localparam int ZB    = 64;
  localparam int DEPTH = 1 << (AW - 5);

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0] reqTag = '0;
  logic [63:0] reqData = '0;
  logic busy, done, fault, ramRdEn, ramWrEn;
  logic [63:0] respData;
  logic [AW-6:0] ramAddr;
  logic [7:0] ramWdata, ramRdata;

  logic [7:0] mem [DEPTH];
  logic [7:0] refMem [DEPTH];
  int wrTotal = 0, rdTotal = 0;
  int checks = 0, errors = 0;
  logic lastFault;
  logic [63:0] lastResp;
  int lastWr, lastRd;

  always #2 clk = ~clk;

  tag_mem_unit #(.ADDR_W(AW), .ZB_BYTES(ZB)) i_tag_mem_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqTag(reqTag), .reqData(reqData), .busy(busy), .done(done), .fault(fault),
    .respData(respData), .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramWrEn(ramWrEn),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  function automatic logic [7:0] seedByte(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seedByte(i);
      ramRdata <= '0;
    end else begin
      if (ramWrEn) begin mem[ramAddr] <= ramWdata; wrTotal <= wrTotal + 1; end
      if (ramRdEn) begin ramRdata <= mem[ramAddr]; rdTotal <= rdTotal + 1; end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkMem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== refMem[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) check(1'b1, req, "tag ram", 0, 0);
    else check(1'b0, req, $sformatf("tag ram byte %0d (%0d bad)", first, bad),
               64'(mem[first]), 64'(refMem[first]));
  endtask

  task automatic doOp(input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [3:0] t, input logic [63:0] d);
    int w0, r0, cyc;
    w0 = wrTotal; r0 = rdTotal;
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqTag = t; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy === 1'b1, "R2", "busy after accept", 64'(busy), 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 100) begin @(negedge clk); cyc++; end
    check(done === 1'b1, "R2", "done reached", 64'(done), 1);
    lastFault = fault; lastResp = respData;
    lastWr = wrTotal - w0; lastRd = rdTotal - r0;
    @(negedge clk);
    check(!busy && !done, "R2", "idle after done", {busy, done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = seedByte(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !fault && !ramRdEn && !ramWrEn, "R1", "reset flags",
          {busy, done, fault, ramRdEn, ramWrEn}, 0);
    check(respData === 64'd0, "R1", "reset respData", respData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R5 R13: single stores over 64 granules
    for (int g = 0; g < 64; g++) begin
      logic [3:0] t;
      t = 4'((g * 5 + 1) & 15);
      doOp(3'd1, AW'(g * 16), t, 64'd0);
      if (g[0]) refMem[g >> 1][7:4] = t; else refMem[g >> 1][3:0] = t;
      check(!lastFault && lastWr == 1 && lastRd == 1, "R5",
            $sformatf("single store g%0d fault/rd/wr", g),
            {lastFault, 8'(lastRd), 8'(lastWr)}, {1'b0, 8'd1, 8'd1});
    end
    checkMem("R5");

    // R8: single loads (unaligned addresses allowed)
    for (int g = 0; g < 64; g++) begin
      logic [63:0] opnd, exp;
      logic [7:0] b;
      opnd = 64'hA5C3_0F1E_2D3C_4B5A ^ 64'(g * 64'h0101_0101);
      b = refMem[g >> 1];
      exp = opnd;
      exp[59:56] = g[0] ? b[7:4] : b[3:0];
      doOp(3'd0, AW'(g * 16 + (g % 16)), 4'd0, opnd);
      check(lastResp === exp && lastWr == 0, "R8", $sformatf("single load g%0d", g),
            lastResp, exp);
    end

    // R6 R7: pair stores
    for (int g = 64; g < 96; g++) begin
      logic [3:0] t;
      t = 4'((g * 3 + 7) & 15);
      doOp(3'd2, AW'(g * 16), t, 64'd0);
      if (g[0]) begin
        refMem[g >> 1][7:4] = t;
        refMem[(g >> 1) + 1][3:0] = t;
        check(lastWr == 2 && !lastFault, "R6", $sformatf("odd pair g%0d writes", g),
              64'(lastWr), 2);
      end else begin
        refMem[g >> 1] = {t, t};
        check(lastWr == 1 && lastRd == 0, "R7", $sformatf("even pair g%0d rd/wr", g),
              {8'(lastRd), 8'(lastWr)}, {8'd0, 8'd1});
      end
    end
    checkMem("R6");

    // R4: misaligned stores fault and write nothing
    for (int k = 1; k < 16; k += 2) begin
      doOp(3'd1, AW'(16'h0200 + k), 4'hF, 64'd0);
      check(lastFault && lastWr == 0, "R4", $sformatf("single misaligned +%0d", k),
            {lastFault, 8'(lastWr)}, {1'b1, 8'd0});
      doOp(3'd2, AW'(16'h0310 + k), 4'hF, 64'd0);
      check(lastFault && lastWr == 0, "R4", $sformatf("pair misaligned +%0d", k),
            {lastFault, 8'(lastWr)}, {1'b1, 8'd0});
    end
    checkMem("R4");

    // R10: bulk store, address aligned down to 256 bytes
    doOp(3'd4, AW'(16'h1037), 4'd0, 64'h0123_4567_89AB_CDEF);
    for (int i = 0; i < 8; i++) refMem[8'h80 + i] = 8'(64'h0123_4567_89AB_CDEF >> (8 * i));
    check(lastWr == 8 && !lastFault, "R10", "bulk store writes", 64'(lastWr), 8);
    checkMem("R10");

    // R9: bulk loads
    doOp(3'd3, AW'(16'h10C5), 4'd0, 64'd0);
    check(lastResp === 64'h0123_4567_89AB_CDEF, "R9", "bulk load stored region",
          lastResp, 64'h0123_4567_89AB_CDEF);
    begin
      logic [63:0] exp;
      for (int i = 0; i < 8; i++) exp[8*i +: 8] = refMem[9'h180 + i];
      doOp(3'd3, AW'(16'h30FF), 4'd0, 64'd0);
      check(lastResp === exp && lastWr == 0, "R9", "bulk load seeded region", lastResp, exp);
    end

    // R11: fills
    doOp(3'd5, AW'(16'h202B), 4'd0, 64'hFFFF_FFFF_FFFF_FF3C);
    refMem[9'h100] = 8'hCC; refMem[9'h101] = 8'hCC;
    check(lastWr == 2, "R11", "fill writes", 64'(lastWr), 2);
    doOp(3'd5, AW'(16'h2070), 4'd0, 64'h0000_0000_0000_0005);
    refMem[9'h102] = 8'h55; refMem[9'h103] = 8'h55;
    checkMem("R11");

    // R12: unused op codes
    for (int op = 6; op < 8; op++) begin
      doOp(3'(op), AW'(16'h0040), 4'h9, 64'hFFFF);
      check(!lastFault && lastWr == 0 && lastRd == 0, "R12", $sformatf("op %0d", op),
            {lastFault, 8'(lastRd), 8'(lastWr)}, 0);
    end
    checkMem("R12");

    // R2: requests while busy are ignored
    reqValid = 1'b1; reqOp = 3'd4; reqAddr = AW'(16'h0800); reqData = 64'h1122_3344_5566_7788;
    @(negedge clk);
    reqOp = 3'd1; reqAddr = AW'(16'h3800); reqTag = 4'hF;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    begin
      int cyc = 0;
      while (done !== 1'b1 && cyc < 100) begin @(negedge clk); cyc++; end
    end
    @(negedge clk);
    for (int i = 0; i < 8; i++) refMem[8'h40 + i] = 8'(64'h1122_3344_5566_7788 >> (8 * i));
    check(!busy, "R2", "idle after busy test", 64'(busy), 0);
    checkMem("R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule